// File: doc/BRIEF.md
# Mode-Selected Four-Function Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit of parameterised width. A single mode bit picks between a bitwise logic group and an adder-based arithmetic group. Two select bits choose one of four functions inside the chosen group. In arithmetic mode a carry input adds one to the sum, so one select code serves both as "plus the ones' complement" and as a true two's-complement subtraction.

The block has three parts. A logic unit produces the bitwise result. An operand conditioner passes, inverts or zeroes each operand ahead of a ripple-carry adder. A final selector picks the result and forms the carry and zero flags. In logic mode both flags are held at zero. Width defaults to 4 bits, and the function table is the same at any width, 16 included.

Top module: `mode_alu`

## Requirements
- R1: With mode=0 the select code {sel_hi,sel_lo} picks the bitwise function of a and b: 00 AND, 01 OR, 10 XOR, 11 XNOR.
- R2: With mode=0, carry_in has no effect on result or on either flag.
- R3: With mode=0, carry_flag and zero_flag are both 0 for every operand value.
- R4: With mode=1 and select 00, result is a when carry_in=0 and a+1 (modulo 2^WIDTH) when carry_in=1.
- R5: With mode=1 and select 01, result is a+b+carry_in modulo 2^WIDTH.
- R6: With mode=1 and select 10, result is a+~b+carry_in modulo 2^WIDTH, which equals a-b when carry_in=1.
- R7: With mode=1 and select 11, result is ~a+b+carry_in modulo 2^WIDTH, which equals b-a when carry_in=1.
- R8: With mode=1, carry_flag is bit WIDTH of the unbounded sum of the two conditioned operands and carry_in, so for subtraction it is 1 when no borrow occurs.
- R9: With mode=1, zero_flag is 1 exactly when every bit of result is 0.
- R10: At WIDTH=16 the same function table and flag rules hold as at WIDTH=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| mode | input | 1 | 0 selects the logic group, 1 selects the arithmetic group |
| sel_hi | input | 1 | Upper function select bit |
| sel_lo | input | 1 | Lower function select bit |
| carry_in | input | 1 | Extra one added in arithmetic mode |
| result | output | WIDTH | Function result |
| carry_flag | output | 1 | Carry out of the most significant adder bit (arithmetic only) |
| zero_flag | output | 1 | Result is all zeros (arithmetic only) |

## Verification
The hardest case is a carry that ripples through every bit position at once. At 16 bits, random operands almost never produce it, as in a+~b+1 with a equal to b, or an increment of an all-ones value. The 4-bit instance is therefore driven over every operand pair under every mode, select and carry combination. The 16-bit instance gets directed all-ones, all-zeros and equal-operand patterns on top of random traffic. Each cycle is compared with an integer reference that uses masked arithmetic instead of a bit-level adder.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // Function select code {sel_hi, sel_lo}; name gives arithmetic / logic meaning
    typedef enum logic [1:0] {
        FN_PASS_AND  = 2'b00,
        FN_ADD_OR    = 2'b01,
        FN_AMB_XOR   = 2'b10,
        FN_BMA_XNOR  = 2'b11
    } fn_sel_e;

    typedef enum logic {
        GRP_LOGIC = 1'b0,
        GRP_ARITH = 1'b1
    } grp_e;

endpackage

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  fn_sel_e          sel,
    output logic [WIDTH-1:0] y
);

    logic [WIDTH-1:0] y_d;

    always_comb begin
        unique case (sel)
            FN_PASS_AND: y_d = a & b;
            FN_ADD_OR:   y_d = a | b;
            FN_AMB_XOR:  y_d = a ^ b;
            default:     y_d = ~(a ^ b);
        endcase
    end

    assign y = y_d;

endmodule

// File: rtl/alu_operand.sv
module alu_operand
    import alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  fn_sel_e          sel,
    output logic [WIDTH-1:0] x,
    output logic [WIDTH-1:0] y
);

    localparam logic [WIDTH-1:0] ALL_ZERO = '0;

    typedef struct packed {
        logic [WIDTH-1:0] x;
        logic [WIDTH-1:0] y;
    } opnd_t;

    opnd_t opnd_d;

    always_comb begin
        opnd_d.x = a;
        opnd_d.y = ALL_ZERO;
        unique case (sel)
            FN_PASS_AND: begin
                opnd_d.x = a;
                opnd_d.y = ALL_ZERO;
            end
            FN_ADD_OR: begin
                opnd_d.x = a;
                opnd_d.y = b;
            end
            FN_AMB_XOR: begin
                opnd_d.x = a;
                opnd_d.y = ~b;
            end
            default: begin
                opnd_d.x = ~a;
                opnd_d.y = b;
            end
        endcase
    end

    assign x = opnd_d.x;
    assign y = opnd_d.y;

endmodule

// File: rtl/alu_ripple.sv
module alu_ripple #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic p_bit;
        logic g_bit_w;
        assign p_bit        = x[i] ^ y[i];
        assign g_bit_w      = x[i] & y[i];
        assign sum[i]       = p_bit ^ chain[i];
        assign chain[i+1]   = g_bit_w | (p_bit & chain[i]);
    end

    assign cout = chain[WIDTH];

endmodule

// File: rtl/mode_alu.sv
module mode_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             mode,
    input  logic             sel_hi,
    input  logic             sel_lo,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_flag,
    output logic             zero_flag
);

    localparam int SUMW = WIDTH + 1;

    typedef struct packed {
        logic [WIDTH-1:0] f;
        logic             carry;
        logic             zero;
    } alu_out_t;

    fn_sel_e          sel;
    grp_e             grp;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] opx;
    logic [WIDTH-1:0] opy;
    logic [WIDTH-1:0] sum;
    logic             cout;
    alu_out_t         out_d;

    assign sel = fn_sel_e'({sel_hi, sel_lo});
    assign grp = grp_e'(mode);

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a   (a),
        .b   (b),
        .sel (sel),
        .y   (logic_y)
    );

    alu_operand #(.WIDTH(WIDTH)) u_operand (
        .a   (a),
        .b   (b),
        .sel (sel),
        .x   (opx),
        .y   (opy)
    );

    alu_ripple #(.WIDTH(WIDTH)) u_adder (
        .x    (opx),
        .y    (opy),
        .cin  (carry_in),
        .sum  (sum),
        .cout (cout)
    );

    // Output selector and flag forming
    always_comb begin
        if (grp == GRP_ARITH) begin
            out_d.f     = sum;
            out_d.carry = cout;
            out_d.zero  = ~|sum;
        end else begin
            out_d.f     = logic_y;
            out_d.carry = 1'b0;
            out_d.zero  = 1'b0;
        end
    end

    assign result     = out_d.f;
    assign carry_flag = out_d.carry;
    assign zero_flag  = out_d.zero;

    // Checks across the separately built pieces
    always_comb begin
        if (mode == 1'b0) begin
            AST_LOGIC_FLAGS_CLEAR: assert (!carry_flag && !zero_flag); // R3
        end
        if (mode && ({sel_hi, sel_lo} == 2'b00) && !carry_in) begin
            AST_PASS_KEEPS_A: assert (result == a && !carry_flag); // R4
        end
        if (mode && ({sel_hi, sel_lo} == 2'b10) && carry_in && (a == b)) begin
            AST_SELF_SUB_ZERO: assert (zero_flag && carry_flag); // R6
        end
        if (mode) begin
            AST_RIPPLE_MATCHES_SUM: assert ({carry_flag, result} ==
                SUMW'({1'b0, opx} + {1'b0, opy} + SUMW'(carry_in))); // R8
        end
        if (mode && zero_flag) begin
            AST_ZERO_MEANS_EMPTY: assert (result == '0); // R9
        end
        if (!mode && ({sel_hi, sel_lo} == 2'b11)) begin
            AST_XNOR_OPPOSES_XOR: assert ((result ^ a ^ b) == {WIDTH{1'b1}}); // R1
        end
    end

endmodule

// File: tb/mode_alu_test.sv
module mode_alu_test;

    localparam int NW = 4;
    localparam int WW = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [NW-1:0] a4, b4, r4;
    logic [WW-1:0] a16, b16, r16;
    logic          m, s1, s0, c0;
    logic          cf4, zf4, cf16, zf16;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    mode_alu #(.WIDTH(NW)) uut (
        .a(a4), .b(b4), .mode(m), .sel_hi(s1), .sel_lo(s0), .carry_in(c0),
        .result(r4), .carry_flag(cf4), .zero_flag(zf4)
    );

    mode_alu #(.WIDTH(WW)) uut_wide (
        .a(a16), .b(b16), .mode(m), .sel_hi(s1), .sel_lo(s0), .carry_in(c0),
        .result(r16), .carry_flag(cf16), .zero_flag(zf16)
    );

    // Reference: returns {zero, carry, f} in low bits, f in [w-1:0]
    function automatic longint ref_alu(int w, bit mm, bit [1:0] sel, bit ci,
                                       longint av, longint bv);
        longint mask = (longint'(1) << w) - 1;
        longint x, y, s, f;
        bit     cy, zr;
        if (!mm) begin
            case (sel)
                2'd0: f = av & bv;
                2'd1: f = av | bv;
                2'd2: f = av ^ bv;
                default: f = (~(av ^ bv)) & mask;
            endcase
            cy = 0; zr = 0;
        end else begin
            x = (sel == 2'd3) ? ((~av) & mask) : av;
            case (sel)
                2'd0: y = 0;
                2'd1: y = bv;
                2'd2: y = (~bv) & mask;
                default: y = bv;
            endcase
            s  = x + y + longint'(ci);
            f  = s & mask;
            cy = ((s >> w) & 1) != 0;
            zr = (f == 0);
        end
        return (longint'(zr) << (w + 1)) | (longint'(cy) << w) | f;
    endfunction

    function automatic string f_tag(bit mm, bit [1:0] sel);
        if (!mm) return "R1";
        case (sel)
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (m=%0b sel=%0b%0b c0=%0b)",
                     tag, act, exp, m, s1, s0, c0);
        end
    endtask

    // Drive after a rising edge, compare at the following falling edge
    task automatic apply(bit mm, bit [1:0] sel, bit ci,
                         logic [NW-1:0] na, logic [NW-1:0] nb,
                         logic [WW-1:0] wa, logic [WW-1:0] wb);
        longint e4, e16;
        string  ft;
        @(posedge clk); #1;
        m = mm; {s1, s0} = sel; c0 = ci;
        a4 = na; b4 = nb; a16 = wa; b16 = wb;
        @(negedge clk);
        e4  = ref_alu(NW, mm, sel, ci, longint'(na), longint'(nb));
        e16 = ref_alu(WW, mm, sel, ci, longint'(wa), longint'(wb));
        ft  = f_tag(mm, sel);
        chk(ft, longint'(r4), e4 & ((longint'(1) << NW) - 1));
        chk(mm ? "R8" : "R3", longint'(cf4), (e4 >> NW) & 1);
        chk(mm ? "R9" : "R3", longint'(zf4), (e4 >> (NW + 1)) & 1);
        chk({"R10/", ft}, longint'({zf16, cf16, r16}), e16);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NW-1:0] keep_r;
        m = 0; s1 = 0; s0 = 0; c0 = 0;
        a4 = '0; b4 = '0; a16 = '0; b16 = '0;

        // Initial quiet state: logic AND of zeros, flags clear (R3)
        @(negedge clk);
        chk("R3", longint'({zf4, cf4, r4}), 0);

        // Exhaustive 4-bit sweep, wide operands padded with random upper bits
        for (int mi = 0; mi < 2; mi++)
            for (int si = 0; si < 4; si++)
                for (int ci = 0; ci < 2; ci++)
                    for (int ai = 0; ai < 16; ai++)
                        for (int bi = 0; bi < 16; bi++)
                            apply(mi[0], si[1:0], ci[0], ai[3:0], bi[3:0],
                                  {$urandom_range(0, 4095), ai[3:0]},
                                  {$urandom_range(0, 4095), bi[3:0]});

        // R2: carry_in has no effect in logic mode
        for (int si = 0; si < 4; si++) begin
            apply(1'b0, si[1:0], 1'b0, 4'hA, 4'h6, 16'hA5C3, 16'h0FF0);
            keep_r = r4;
            apply(1'b0, si[1:0], 1'b1, 4'hA, 4'h6, 16'hA5C3, 16'h0FF0);
            chk("R2", longint'({zf4, cf4, r4}), longint'(keep_r));
        end

        // Wide corner cases (R10): full-length ripples and equal operands
        apply(1'b1, 2'd0, 1'b1, 4'hF, 4'h0, 16'hFFFF, 16'h0000);
        apply(1'b1, 2'd2, 1'b1, 4'h7, 4'h7, 16'h8001, 16'h8001);
        apply(1'b1, 2'd3, 1'b1, 4'h3, 4'h3, 16'h1234, 16'h1234);
        apply(1'b1, 2'd1, 1'b1, 4'hF, 4'hF, 16'hFFFF, 16'hFFFF);
        apply(1'b1, 2'd1, 1'b0, 4'h8, 4'h8, 16'h8000, 16'h8000);
        apply(1'b1, 2'd2, 1'b1, 4'h0, 4'h1, 16'h0000, 16'h0001);
        apply(1'b0, 2'd3, 1'b1, 4'h5, 4'h5, 16'hFFFF, 16'hFFFF);

        // Random wide traffic
        for (int k = 0; k < 2000; k++) begin
            logic [31:0] rv;
            rv = $urandom;
            apply(rv[0], rv[2:1], rv[3], rv[7:4], rv[11:8],
                  $urandom_range(0, 65535), $urandom_range(0, 65535));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule